// File: doc/BRIEF.md
# Fabric Cell Sender with Two-Way NACK Retry

This block feeds fixed-length cells from a set of per-channel queues into a switch fabric. The fabric is reached through several independent nibble-wide ports. Each port has its own scheduler and serializer. When a port is free and the fabric is not holding it back, it picks a channel that has a cell ready. It then streams that cell one nibble per clock, fetching each nibble from the queue memory by channel and nibble index. After the cell it waits for the fabric's verdict.

The verdict decides what happens to the cell. A positive acknowledgment dequeues the cell and moves the round-robin pointer on. A medium negative acknowledgment signals a short-lived collision, so the cell is kept and sent again in the very next slot. An output negative acknowledgment signals a destination that will stay blocked. The cell is kept at the head of its queue, and the next slot goes to a different channel, so one stuck destination cannot starve traffic bound elsewhere. Two saturating counters per port record how many negative acknowledgments of each kind arrived.

Top module: `fcs_fabric_tx`

## Requirements
- R1: After reset no port sends (valid, start-of-cell, dequeue and keep are low), all counters read 0, and the round-robin pointer of every port starts at channel 0.
- R2: A cell is 106 nibbles on consecutive clocks with valid high throughout. Nibble k carries the queue data presented for nibble index k of the chosen channel, index 0 first, so the most significant nibble leads. Start-of-cell is high with nibble 0 only.
- R3: A port does not start a new cell while its backpressure input is high. Once backpressure is released, it starts a pending cell.
- R4: While a port waits for the acknowledgment and the code is 00 (none), nothing happens: valid stays low and no dequeue or keep pulse is issued.
- R5: Code 01 (ACK) gives a one-cycle dequeue pulse with the command channel equal to the sent channel. The next cell goes to the first ready channel after it, in round-robin order.
- R6: Code 10 (medium NACK) gives a one-cycle keep pulse. The next cell resends the same channel even when other channels are ready.
- R7: Code 11 (output NACK) gives a one-cycle keep pulse. The next cell comes from a different ready channel, namely the first ready one after the refused channel in round-robin order.
- R8: A channel refused by an output NACK is passed over for one slot only and is eligible again afterwards. If it is the only ready channel, it is retried at once.
- R9: Per port, the medium-NACK and output-NACK counters each add one per such code and stop at 2^CNT_W-1.
- R10: Ports are independent: one port's backpressure, readiness and acknowledgments do not change another port's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_rdy | input | NP*NC | Cell-ready flag per port and channel, port p at bits [p*NC +: NC] |
| fab_bp | input | NP | Backpressure from the fabric, one per port |
| ack_code | input | 2*NP | Acknowledgment code per port: 00 none, 01 ACK, 10 medium NACK, 11 output NACK |
| rd_ch | output | NP*CHW | Channel whose cell memory is being read |
| rd_idx | output | NP*IDXW | Nibble index being read |
| rd_nib | input | NP*NIB_W | Nibble returned by the queue memory for rd_ch/rd_idx |
| fab_nib | output | NP*NIB_W | Cell nibble to the fabric |
| fab_vld | output | NP | Nibble valid |
| fab_sof | output | NP | Start-of-cell, with the first nibble |
| deq_pulse | output | NP | Remove the head cell of cmd_ch |
| keep_pulse | output | NP | Keep the head cell of cmd_ch |
| cmd_ch | output | NP*CHW | Channel the dequeue or keep pulse refers to |
| mnack_cnt | output | NP*CNT_W | Saturating medium-NACK count |
| onack_cnt | output | NP*CNT_W | Saturating output-NACK count |

## Verification
The bench aims at the split between the two NACK kinds. A design that resends on an output NACK would show the refused channel again while another channel is ready. A design that skips on a medium NACK would move to a new channel instead of resending. It also checks that the skip lasts one slot only, by refusing two channels in turn and expecting the first to come back. It checks the sole-ready case, where a design that made skipping absolute would stall. Backpressure held across a pending cell, a long silence on the acknowledgment code, and driving one port while another is held are checked for spurious starts or pulses. More than 255 medium NACKs push a counter to its ceiling, where a wrapping counter would return to a small value.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } fcs_state_e;

  localparam logic [1:0] ACK_NONE = 2'b00;
  localparam logic [1:0] ACK_POS  = 2'b01;
  localparam logic [1:0] ACK_MED  = 2'b10;
  localparam logic [1:0] ACK_OUT  = 2'b11;

  // First set bit of req at or after start, wrapping over n entries.
  function automatic int unsigned rr_first(logic [31:0] req, int unsigned start,
                                           int unsigned n);
    int unsigned res;
    logic        found;
    res   = 0;
    found = 1'b0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && !found) begin
        if (req[(start + i) % n]) begin
          res   = (start + i) % n;
          found = 1'b1;
        end
      end
    end
    return res;
  endfunction

  // Channel after c in circular order.
  function automatic int unsigned ch_after(int unsigned c, int unsigned n);
    return (c + 1 >= n) ? 0 : c + 1;
  endfunction

endpackage

// File: rtl/fcs_pick.sv
module fcs_pick #(
  parameter int NC  = 4,
  parameter int CHW = 2
) (
  input  logic [NC-1:0]  rdy,
  input  logic [CHW-1:0] ptr,
  input  logic           skip_vld,
  input  logic [CHW-1:0] skip_ch,
  input  logic           resend,
  input  logic [CHW-1:0] cur_ch,
  output logic           any_rdy,
  output logic           alt_rdy,
  output logic [CHW-1:0] pick_ch
);
  import fcs_pkg::*;

  logic [NC-1:0] skip_mask;
  logic [NC-1:0] avail;

  always_comb begin
    skip_mask = '0;
    if (skip_vld) skip_mask[skip_ch] = 1'b1;
  end

  assign avail   = rdy & ~skip_mask;
  assign any_rdy = |rdy;
  assign alt_rdy = |avail;

  always_comb begin
    if (resend && rdy[cur_ch])
      pick_ch = cur_ch;
    else if (alt_rdy)
      pick_ch = CHW'(rr_first(32'(avail), 32'(ptr), NC));
    else
      pick_ch = CHW'(rr_first(32'(rdy), 32'(ptr), NC));
  end

endmodule

// File: rtl/fcs_sat_ctr.sv
module fcs_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                q <= '0;
    else if (inc && q != TOP)  q <= q + 1'b1;
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && q == TOP) |=> (q == TOP));

  // R9
  sat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && q != TOP) |=> (q == $past(q) + 1'b1));

endmodule

// File: rtl/fcs_port.sv
module fcs_port #(
  parameter int NC       = 4,
  parameter int CHW      = 2,
  parameter int CELL_NIB = 106,
  parameter int IDXW     = 7,
  parameter int NIB_W    = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC-1:0]    rdy,
  input  logic             bp,
  input  logic [1:0]       ack,
  input  logic [NIB_W-1:0] rd_nib,
  output logic [CHW-1:0]   rd_ch,
  output logic [IDXW-1:0]  rd_idx,
  output logic [NIB_W-1:0] nib,
  output logic             vld,
  output logic             sof,
  output logic             deq,
  output logic             keep,
  output logic [CHW-1:0]   cmd_ch,
  output logic [CNT_W-1:0] mnack_cnt,
  output logic [CNT_W-1:0] onack_cnt
);
  import fcs_pkg::*;

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(CELL_NIB - 1);

  fcs_state_e     state;
  logic [IDXW-1:0] idx;
  logic [CHW-1:0] cur_ch, ptr, skip_ch, pick_ch;
  logic           skip_vld, resend, deq_q, keep_q;
  logic           any_rdy, alt_rdy;

  // Named events for the checks below
  logic start_evt, last_evt, ack_evt, pos_evt, med_evt, out_evt;
  assign start_evt = (state == ST_IDLE) && !bp && any_rdy;
  assign last_evt  = (state == ST_SEND) && (idx == LAST_IDX);
  assign ack_evt   = (state == ST_WAIT) && (ack != ACK_NONE);
  assign pos_evt   = ack_evt && (ack == ACK_POS);
  assign med_evt   = ack_evt && (ack == ACK_MED);
  assign out_evt   = ack_evt && (ack == ACK_OUT);

  fcs_pick #(.NC(NC), .CHW(CHW)) u_pick (
    .rdy(rdy), .ptr(ptr), .skip_vld(skip_vld), .skip_ch(skip_ch),
    .resend(resend), .cur_ch(cur_ch),
    .any_rdy(any_rdy), .alt_rdy(alt_rdy), .pick_ch(pick_ch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      cur_ch   <= '0;
      ptr      <= '0;
      skip_vld <= 1'b0;
      skip_ch  <= '0;
      resend   <= 1'b0;
      deq_q    <= 1'b0;
      keep_q   <= 1'b0;
    end else begin
      deq_q  <= 1'b0;
      keep_q <= 1'b0;
      case (state)
        ST_IDLE: if (start_evt) begin
          state    <= ST_SEND;
          idx      <= '0;
          cur_ch   <= pick_ch;
          skip_vld <= 1'b0;
          resend   <= 1'b0;
        end
        ST_SEND: begin
          if (last_evt) state <= ST_WAIT;
          else          idx   <= idx + 1'b1;
        end
        ST_WAIT: if (ack_evt) begin
          state <= ST_IDLE;
          if (pos_evt) begin
            deq_q <= 1'b1;
            ptr   <= CHW'(ch_after(32'(cur_ch), NC));
          end
          if (med_evt) begin
            keep_q <= 1'b1;
            resend <= 1'b1;
          end
          if (out_evt) begin
            keep_q   <= 1'b1;
            skip_vld <= 1'b1;
            skip_ch  <= cur_ch;
            ptr      <= CHW'(ch_after(32'(cur_ch), NC));
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_ch  = cur_ch;
  assign rd_idx = idx;
  assign vld    = (state == ST_SEND);
  assign sof    = vld && (idx == '0);
  assign nib    = vld ? rd_nib : '0;
  assign deq    = deq_q;
  assign keep   = keep_q;
  assign cmd_ch = cur_ch;

  fcs_sat_ctr #(.W(CNT_W)) u_mcnt (.clk(clk), .rst_n(rst_n), .inc(med_evt), .q(mnack_cnt));
  fcs_sat_ctr #(.W(CNT_W)) u_ocnt (.clk(clk), .rst_n(rst_n), .inc(out_evt), .q(onack_cnt));

  // R2
  sof_in_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> vld);

  // R3
  bp_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp |=> !sof);

  // R4
  ack_ends_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> !vld);

  // R5
  deq_keep_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(deq && keep));

  // R6
  resend_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && resend && rdy[cur_ch]) |=> (cur_ch == $past(cur_ch)));

  // R7
  skip_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && skip_vld && alt_rdy) |=> (cur_ch != $past(skip_ch)));

endmodule

// File: rtl/fcs_fabric_tx.sv
module fcs_fabric_tx #(
  parameter int NP       = 4,
  parameter int NC       = 4,
  parameter int CELL_NIB = 106,
  parameter int NIB_W    = 4,
  parameter int CNT_W    = 8,
  localparam int CHW     = (NC > 1) ? $clog2(NC) : 1,
  localparam int IDXW    = $clog2(CELL_NIB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NP*NC-1:0]    ch_rdy,
  input  logic [NP-1:0]       fab_bp,
  input  logic [2*NP-1:0]     ack_code,
  output logic [NP*CHW-1:0]   rd_ch,
  output logic [NP*IDXW-1:0]  rd_idx,
  input  logic [NP*NIB_W-1:0] rd_nib,
  output logic [NP*NIB_W-1:0] fab_nib,
  output logic [NP-1:0]       fab_vld,
  output logic [NP-1:0]       fab_sof,
  output logic [NP-1:0]       deq_pulse,
  output logic [NP-1:0]       keep_pulse,
  output logic [NP*CHW-1:0]   cmd_ch,
  output logic [NP*CNT_W-1:0] mnack_cnt,
  output logic [NP*CNT_W-1:0] onack_cnt
);

  for (genvar p = 0; p < NP; p++) begin : g_port
    fcs_port #(
      .NC(NC), .CHW(CHW), .CELL_NIB(CELL_NIB), .IDXW(IDXW),
      .NIB_W(NIB_W), .CNT_W(CNT_W)
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .rdy      (ch_rdy[p*NC +: NC]),
      .bp       (fab_bp[p]),
      .ack      (ack_code[2*p +: 2]),
      .rd_nib   (rd_nib[p*NIB_W +: NIB_W]),
      .rd_ch    (rd_ch[p*CHW +: CHW]),
      .rd_idx   (rd_idx[p*IDXW +: IDXW]),
      .nib      (fab_nib[p*NIB_W +: NIB_W]),
      .vld      (fab_vld[p]),
      .sof      (fab_sof[p]),
      .deq      (deq_pulse[p]),
      .keep     (keep_pulse[p]),
      .cmd_ch   (cmd_ch[p*CHW +: CHW]),
      .mnack_cnt(mnack_cnt[p*CNT_W +: CNT_W]),
      .onack_cnt(onack_cnt[p*CNT_W +: CNT_W])
    );
  end

endmodule

// File: tb/sim_fcs_fabric_tx.sv
`timescale 1ns/1ps
module sim_fcs_fabric_tx;
  localparam int NP = 4, NC = 4, CN = 106, NW = 4, CW = 8, CHW = 2, IW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP*NC-1:0] ch_rdy = '0;
  logic [NP-1:0]    fab_bp = '0;
  logic [2*NP-1:0]  ack_code = '0;
  logic [NP*CHW-1:0] rd_ch, cmd_ch;
  logic [NP*IW-1:0]  rd_idx;
  logic [NP*NW-1:0]  rd_nib, fab_nib;
  logic [NP-1:0]     fab_vld, fab_sof, deq_pulse, keep_pulse;
  logic [NP*CW-1:0]  mnack_cnt, onack_cnt;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  fcs_fabric_tx #(.NP(NP), .NC(NC), .CELL_NIB(CN), .NIB_W(NW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_rdy(ch_rdy), .fab_bp(fab_bp), .ack_code(ack_code),
    .rd_ch(rd_ch), .rd_idx(rd_idx), .rd_nib(rd_nib), .fab_nib(fab_nib),
    .fab_vld(fab_vld), .fab_sof(fab_sof), .deq_pulse(deq_pulse),
    .keep_pulse(keep_pulse), .cmd_ch(cmd_ch), .mnack_cnt(mnack_cnt),
    .onack_cnt(onack_cnt)
  );

  // Queue memory model: content per port, channel and nibble index.
  function automatic logic [3:0] qnib(int p, int ch, int k);
    return 4'((p * 7 + ch * 5 + k * 3 + (k >> 4)) % 16);
  endfunction

  always_comb begin
    for (int p = 0; p < NP; p++)
      rd_nib[p*NW +: NW] = qnib(p, int'(rd_ch[p*CHW +: CHW]), int'(rd_idx[p*IW +: IW]));
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic set_rdy(input int p, input logic [NC-1:0] m);
    ch_rdy[p*NC +: NC] = m;
  endtask

  // Wait for a cell on port p, check channel and content; returns at a negedge in the wait state.
  task automatic recv_cell(input int p, input int exp_ch, input string tag);
    int w = 0, bad = 0;
    while (!fab_sof[p] && w < 400) begin @(negedge clk); w++; end
    if (!fab_sof[p]) begin chk(1'b0, {tag, " no start of cell"}, 0, 1); return; end
    chk(int'(rd_ch[p*CHW +: CHW]) == exp_ch, {tag, " channel"}, int'(rd_ch[p*CHW +: CHW]), exp_ch);
    for (int k = 0; k < CN; k++) begin
      if (!fab_vld[p] || fab_sof[p] != (k == 0) ||
          fab_nib[p*NW +: NW] != qnib(p, exp_ch, k)) bad++;
      @(negedge clk);
    end
    // R2: every nibble in order, valid throughout, start-of-cell on the first only
    chk(bad == 0, {tag, " R2 cell content"}, bad, 0);
    chk(!fab_vld[p], {tag, " R2 valid drops after cell"}, int'(fab_vld[p]), 0);
  endtask

  task automatic reply(input int p, input logic [1:0] code, input int exp_ch, input string tag);
    ack_code[2*p +: 2] = code;
    @(negedge clk);
    ack_code[2*p +: 2] = 2'b00;
    chk(deq_pulse[p] == (code == 2'b01), {tag, " dequeue pulse"}, int'(deq_pulse[p]), int'(code == 2'b01));
    chk(keep_pulse[p] == (code[1]), {tag, " keep pulse"}, int'(keep_pulse[p]), int'(code[1]));
    chk(int'(cmd_ch[p*CHW +: CHW]) == exp_ch, {tag, " command channel"}, int'(cmd_ch[p*CHW +: CHW]), exp_ch);
  endtask

  task automatic t_reset;
    chk(fab_vld == '0 && fab_sof == '0, "R1 no output after reset", int'(fab_vld), 0);
    chk(deq_pulse == '0 && keep_pulse == '0, "R1 no pulses after reset", int'(deq_pulse | keep_pulse), 0);
    chk(mnack_cnt == '0 && onack_cnt == '0, "R1 counters zero", int'(mnack_cnt[7:0]), 0);
  endtask

  task automatic t_round_robin;
    int exp[5] = '{0, 1, 2, 3, 0};
    set_rdy(0, 4'b1111);
    foreach (exp[i]) begin
      recv_cell(0, exp[i], "R1 R5 round robin");
      reply(0, 2'b01, exp[i], "R5 ack");
    end
    set_rdy(0, 4'b0000);
  endtask

  task automatic t_medium;
    set_rdy(0, 4'b1111);
    recv_cell(0, 1, "R6 first");
    reply(0, 2'b10, 1, "R6 medium nack");
    recv_cell(0, 1, "R6 resend same channel");
    reply(0, 2'b01, 1, "R6 ack");
    set_rdy(0, 4'b0000);
    chk(mnack_cnt[7:0] == 8'd1, "R9 medium count", int'(mnack_cnt[7:0]), 1);
  endtask

  task automatic t_output;
    set_rdy(0, 4'b1111);
    recv_cell(0, 2, "R7 first");
    reply(0, 2'b11, 2, "R7 output nack");
    recv_cell(0, 3, "R7 other channel");
    reply(0, 2'b01, 3, "R7 ack");
    set_rdy(0, 4'b0000);
    chk(onack_cnt[7:0] == 8'd1, "R9 output count", int'(onack_cnt[7:0]), 1);
  endtask

  task automatic t_sole;
    set_rdy(0, 4'b0100);
    recv_cell(0, 2, "R8 sole first");
    reply(0, 2'b11, 2, "R8 sole output nack");
    recv_cell(0, 2, "R8 sole retried");
    reply(0, 2'b01, 2, "R8 sole ack");
    set_rdy(0, 4'b0000);
  endtask

  task automatic t_skip_once;
    // pointer at 3, channels 0 and 1 ready
    set_rdy(0, 4'b0011);
    recv_cell(0, 0, "R8 skip a");
    reply(0, 2'b11, 0, "R8 refuse 0");
    recv_cell(0, 1, "R8 skip b");
    reply(0, 2'b11, 1, "R8 refuse 1");
    recv_cell(0, 0, "R8 channel 0 eligible again");
    reply(0, 2'b01, 0, "R8 ack");
    set_rdy(0, 4'b0000);
    chk(onack_cnt[7:0] == 8'd4, "R9 output count after skips", int'(onack_cnt[7:0]), 4);
  endtask

  task automatic t_backpressure;
    int seen = 0;
    fab_bp[0] = 1'b1;
    set_rdy(0, 4'b1111);
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (fab_vld[0]) seen++; end
    chk(seen == 0, "R3 no start under backpressure", seen, 0);
    fab_bp[0] = 1'b0;
    recv_cell(0, 1, "R3 start after release");
    reply(0, 2'b01, 1, "R3 ack");
    set_rdy(0, 4'b0000);
  endtask

  task automatic t_silence;
    int bad = 0;
    set_rdy(0, 4'b0100);
    recv_cell(0, 2, "R4 cell");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (fab_vld[0] || deq_pulse[0] || keep_pulse[0]) bad++;
    end
    chk(bad == 0, "R4 idle while code is none", bad, 0);
    reply(0, 2'b01, 2, "R4 late ack");
    set_rdy(0, 4'b0000);
  endtask

  task automatic t_ports;
    int seen = 0;
    fab_bp[0] = 1'b1;
    set_rdy(0, 4'b1111);
    set_rdy(1, 4'b0010);
    recv_cell(1, 1, "R10 port 1 cell");
    reply(1, 2'b01, 1, "R10 port 1 ack");
    set_rdy(1, 4'b0000);
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (fab_vld[0]) seen++; end
    chk(seen == 0 && deq_pulse[0] == 1'b0, "R10 port 0 unaffected", seen, 0);
    chk(mnack_cnt[0 +: 8] == 8'd1, "R10 port 0 count unchanged", int'(mnack_cnt[0 +: 8]), 1);
    set_rdy(0, 4'b0000);
    fab_bp[0] = 1'b0;
  endtask

  task automatic t_saturate;
    set_rdy(2, 4'b0001);
    for (int i = 0; i < 260; i++) begin
      int w = 0;
      while (!fab_sof[2] && w < 400) begin @(negedge clk); w++; end
      repeat (CN) @(negedge clk);
      ack_code[5:4] = 2'b10;
      @(negedge clk);
      ack_code[5:4] = 2'b00;
      if (i == 9) chk(mnack_cnt[2*CW +: CW] == 8'd10, "R9 count before ceiling",
                      int'(mnack_cnt[2*CW +: CW]), 10);
    end
    set_rdy(2, 4'b0000);
    chk(mnack_cnt[2*CW +: CW] == 8'd255, "R9 medium count saturates", int'(mnack_cnt[2*CW +: CW]), 255);
    chk(onack_cnt[2*CW +: CW] == 8'd0, "R9 output count untouched", int'(onack_cnt[2*CW +: CW]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round_robin();
    t_medium();
    t_output();
    t_sole();
    t_skip_once();
    t_backpressure();
    t_silence();
    t_ports();
    t_saturate();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule